// File: doc/BRIEF.md
# Floating-Point Register Rename Status Table

This block holds the architectural floating-point register values together with, for each register, the identity of the in-flight operation that will next write it. When an operation is dispatched, both of its source registers are looked up in the same cycle. Each lookup returns either a ready value or the tag of the station that will produce the value. The destination register is then claimed by the new producer's tag, which replaces any older claim. Because of this, later readers only ever wait on the youngest writer, and false (write-after-read and write-after-write) dependences never stall dispatch.

Results come back over a single broadcast path that carries a 64-bit value and a 4-bit producer tag. A register takes the broadcast value only while its recorded tag still names that producer. If a younger writer has claimed the register since, the value is dropped. Each register entry is a small two-state machine. The states are READY (holds a usable value) and PENDING (waiting on a tag). It has three named transitions: CLAIM (READY to PENDING on issue), RECLAIM (PENDING to PENDING with a new tag on issue) and RETIRE (PENDING to READY on a matching broadcast). A lookup made in the same cycle as a matching broadcast sees the broadcast value directly.

Top module: `fpr_rename_table`

## Requirements
- R1: After reset every register is READY and holds the value zero; a lookup returns busy 0, tag 0 and value 0.
- R2: A lookup of a READY register returns busy 0, tag 0 and the stored value, combinationally in the same cycle as the address.
- R3: An issue with `iss_valid_i` 1 puts register `iss_dst_i` in PENDING with tag `iss_tag_i` from the next cycle on. A later issue to the same register replaces the older tag. A lookup of a PENDING register returns busy 1, the recorded tag, and the stale stored value.
- R4: A broadcast (`bc_valid_i` 1) whose tag equals the recorded tag of a PENDING register writes the broadcast data into that register and returns it to READY in the next cycle.
- R5: A broadcast has no effect on a register whose tag differs from the broadcast tag, or on a register that is READY.
- R6: When an issue claims a register in the same cycle as a broadcast matching that register's old tag, the new tag is kept and the stored value is not written.
- R7: A lookup in the same cycle as a broadcast matching the looked-up PENDING register returns busy 0, tag 0 and the broadcast data.
- R8: A lookup in the same cycle as an issue claiming the same register returns the register's status from before that issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | An operation is dispatched this cycle |
| iss_dst_i | input | 4 | Destination register of the dispatched operation |
| iss_tag_i | input | 4 | Station tag of the dispatched operation |
| src_a_i | input | 4 | First lookup register address |
| src_b_i | input | 4 | Second lookup register address |
| bc_valid_i | input | 1 | A result is broadcast this cycle |
| bc_tag_i | input | 4 | Producer tag of the broadcast result |
| bc_data_i | input | 64 | Broadcast result value |
| a_busy_o | output | 1 | First lookup: value not yet available |
| a_tag_o | output | 4 | First lookup: producer tag (0 when not busy) |
| a_val_o | output | 64 | First lookup: value |
| b_busy_o | output | 1 | Second lookup: value not yet available |
| b_tag_o | output | 4 | Second lookup: producer tag (0 when not busy) |
| b_val_o | output | 64 | Second lookup: value |

## Verification
Two cases of functions falling in the same cycle carry the risk. In the first, an issue re-claims a register while a broadcast for its old producer arrives; this is provoked by dispatching a new writer to a register exactly in its producer's completion cycle. That case is judged by reading the register one cycle later, which must show the new tag and the untouched old value. In the second, a lookup coincides with a matching broadcast or with an issue to the same register; these are judged in the same cycle by the bypassed value, or by the pre-issue status.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    localparam int unsigned REG_COUNT = 16;
    localparam int unsigned DATA_W    = 64;
    localparam int unsigned TAG_W     = 4;

    typedef enum logic {
        ENT_READY   = 1'b0,
        ENT_PENDING = 1'b1
    } ent_state_e;
endpackage

// File: rtl/rrs_entry.sv
module rrs_entry
    import rrs_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned TW = TAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim_i,
    input  logic [TW-1:0] claim_tag_i,
    input  logic          bc_valid_i,
    input  logic [TW-1:0] bc_tag_i,
    input  logic [DW-1:0] bc_data_i,
    output logic          pend_o,
    output logic [TW-1:0] tag_o,
    output logic [DW-1:0] value_o
);
    ent_state_e    state_q, state_n;
    logic [TW-1:0] tag_q, tag_n;
    logic [DW-1:0] value_q, value_n;
    logic          match;

    assign match = bc_valid_i && (state_q == ENT_PENDING) && (tag_q == bc_tag_i);

    // next state: CLAIM, RECLAIM, RETIRE
    always_comb begin
        state_n = state_q;
        tag_n   = tag_q;
        value_n = value_q;
        unique case (state_q)
            ENT_READY: begin
                if (claim_i) begin
                    state_n = ENT_PENDING;
                    tag_n   = claim_tag_i;
                end
            end
            ENT_PENDING: begin
                if (claim_i) begin
                    tag_n = claim_tag_i;
                end else if (match) begin
                    state_n = ENT_READY;
                    value_n = bc_data_i;
                end
            end
            default: state_n = ENT_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_READY;
            tag_q   <= '0;
            value_q <= '0;
        end else begin
            state_q <= state_n;
            tag_q   <= tag_n;
            value_q <= value_n;
        end
    end

    // outputs
    always_comb begin
        pend_o  = (state_q == ENT_PENDING);
        tag_o   = tag_q;
        value_o = value_q;
    end

    p_claim_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |=> (pend_o && tag_o == $past(claim_tag_i)));

    p_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_i && bc_valid_i && pend_o && tag_o == bc_tag_i)
        |=> (!pend_o && value_o == $past(bc_data_i)));

    p_no_match_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_i && !(bc_valid_i && pend_o && tag_o == bc_tag_i))
        |=> ($stable(value_o) && $stable(pend_o)));

    p_claim_keeps_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |=> $stable(value_o));
endmodule

// File: rtl/rrs_read_port.sv
module rrs_read_port
    import rrs_pkg::*;
#(
    parameter int unsigned NR = REG_COUNT,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned TW = TAG_W,
    localparam int unsigned AW = $clog2(NR)
) (
    input  logic [AW-1:0]         addr_i,
    input  logic [NR-1:0]         pend_i,
    input  logic [NR-1:0][TW-1:0] tags_i,
    input  logic [NR-1:0][DW-1:0] vals_i,
    input  logic                  bc_valid_i,
    input  logic [TW-1:0]         bc_tag_i,
    input  logic [DW-1:0]         bc_data_i,
    output logic                  busy_o,
    output logic [TW-1:0]         tag_o,
    output logic [DW-1:0]         val_o
);
    logic          sel_pend;
    logic [TW-1:0] sel_tag;
    logic          bypass;

    always_comb begin
        sel_pend = pend_i[addr_i];
        sel_tag  = tags_i[addr_i];
        bypass   = sel_pend && bc_valid_i && (sel_tag == bc_tag_i);
        busy_o   = sel_pend && !bypass;
        tag_o    = busy_o ? sel_tag : '0;
        val_o    = bypass ? bc_data_i : vals_i[addr_i];
    end
endmodule

// File: rtl/fpr_rename_table.sv
module fpr_rename_table
    import rrs_pkg::*;
#(
    parameter int unsigned NUM_REGS = REG_COUNT,
    parameter int unsigned DW       = DATA_W,
    parameter int unsigned TW       = TAG_W,
    localparam int unsigned AW      = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid_i,
    input  logic [AW-1:0] iss_dst_i,
    input  logic [TW-1:0] iss_tag_i,
    input  logic [AW-1:0] src_a_i,
    input  logic [AW-1:0] src_b_i,
    input  logic          bc_valid_i,
    input  logic [TW-1:0] bc_tag_i,
    input  logic [DW-1:0] bc_data_i,
    output logic          a_busy_o,
    output logic [TW-1:0] a_tag_o,
    output logic [DW-1:0] a_val_o,
    output logic          b_busy_o,
    output logic [TW-1:0] b_tag_o,
    output logic [DW-1:0] b_val_o
);
    logic [NUM_REGS-1:0]         pend;
    logic [NUM_REGS-1:0][TW-1:0] tags;
    logic [NUM_REGS-1:0][DW-1:0] vals;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        logic claim;
        assign claim = iss_valid_i && (iss_dst_i == AW'(i));
        rrs_entry #(.DW(DW), .TW(TW)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .claim_i    (claim),
            .claim_tag_i(iss_tag_i),
            .bc_valid_i (bc_valid_i),
            .bc_tag_i   (bc_tag_i),
            .bc_data_i  (bc_data_i),
            .pend_o     (pend[i]),
            .tag_o      (tags[i]),
            .value_o    (vals[i])
        );
    end

    rrs_read_port #(.NR(NUM_REGS), .DW(DW), .TW(TW)) u_rd_a (
        .addr_i(src_a_i), .pend_i(pend), .tags_i(tags), .vals_i(vals),
        .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
        .busy_o(a_busy_o), .tag_o(a_tag_o), .val_o(a_val_o)
    );

    rrs_read_port #(.NR(NUM_REGS), .DW(DW), .TW(TW)) u_rd_b (
        .addr_i(src_b_i), .pend_i(pend), .tags_i(tags), .vals_i(vals),
        .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
        .busy_o(b_busy_o), .tag_o(b_tag_o), .val_o(b_val_o)
    );

    // R7 / R2: a ready (or bypassed) result stays visible next cycle if nothing claims it
    p_ready_persists_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_valid_i && !a_busy_o) ##1 (src_a_i == $past(src_a_i))
        |-> (!a_busy_o && a_val_o == $past(a_val_o)));

    p_ready_tag_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_busy_o) |-> (b_tag_o == '0));
endmodule

// File: tb/tb_fpr_rename_table.sv
module tb_fpr_rename_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid_i = 1'b0;
    logic [3:0]  iss_dst_i = '0, iss_tag_i = '0, src_a_i = '0, src_b_i = '0;
    logic        bc_valid_i = 1'b0;
    logic [3:0]  bc_tag_i = '0;
    logic [63:0] bc_data_i = '0;
    logic        a_busy_o, b_busy_o;
    logic [3:0]  a_tag_o, b_tag_o;
    logic [63:0] a_val_o, b_val_o;

    always #5 clk = ~clk;

    fpr_rename_table dut (.*);

    typedef struct {
        int          port;
        logic        busy;
        logic [3:0]  tag;
        logic [63:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done = 0;

    localparam logic [63:0] D1 = 64'hAAAA_5555_0000_FFFF;
    localparam logic [63:0] D2 = 64'h0000_0000_0000_1234;
    localparam logic [63:0] D3 = 64'h0000_0000_0000_0055;
    localparam logic [63:0] D4 = 64'h0000_0000_0000_0077;

    task automatic cyc(input logic iv, input logic [3:0] dst, input logic [3:0] tg,
                       input logic [3:0] sa, input logic [3:0] sb,
                       input logic bv, input logic [3:0] bt, input logic [63:0] bd);
        @(posedge clk);
        #1;
        iss_valid_i = iv; iss_dst_i = dst; iss_tag_i = tg;
        src_a_i = sa; src_b_i = sb;
        bc_valid_i = bv; bc_tag_i = bt; bc_data_i = bd;
    endtask

    task automatic expect_rd(input int port, input logic busy, input logic [3:0] tg,
                             input logic [63:0] v, input string req);
        exp_t e;
        e.port = port; e.busy = busy; e.tag = tg; e.val = v; e.req = req;
        q.push_back(e);
    endtask

    // monitor: compare at the falling edge of the cycle the items were queued in
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            logic        b;
            logic [3:0]  t;
            logic [63:0] v;
            e = q.pop_front();
            b = (e.port == 0) ? a_busy_o : b_busy_o;
            t = (e.port == 0) ? a_tag_o  : b_tag_o;
            v = (e.port == 0) ? a_val_o  : b_val_o;
            checks++;
            if (b !== e.busy || t !== e.tag || v !== e.val) begin
                errors++;
                $display("FAIL %s port%0d: got busy=%0b tag=%0d val=%h, expected busy=%0b tag=%0d val=%h",
                         e.req, e.port, b, t, v, e.busy, e.tag, e.val);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        cyc(0, 0, 0, 4'd0, 4'd5, 0, 0, '0);
        expect_rd(0, 0, 0, '0, "R1"); expect_rd(1, 0, 0, '0, "R1");
        // R8: lookup during claim of same register sees old status
        cyc(1, 4'd3, 4'd5, 4'd3, 4'd0, 0, 0, '0);
        expect_rd(0, 0, 0, '0, "R8");
        // R3: pending with tag 5; reclaim with tag 9
        cyc(1, 4'd3, 4'd9, 4'd3, 4'd0, 0, 0, '0);
        expect_rd(0, 1, 4'd5, '0, "R3");
        // R3 tag replaced; R5 stale broadcast (tag 5) ignored, no bypass
        cyc(0, 0, 0, 4'd3, 4'd3, 1, 4'd5, D2);
        expect_rd(0, 1, 4'd9, '0, "R3"); expect_rd(1, 1, 4'd9, '0, "R5");
        // R7: matching broadcast bypasses to lookup
        cyc(0, 0, 0, 4'd3, 4'd0, 1, 4'd9, D1);
        expect_rd(0, 0, 0, D1, "R7");
        // R4: value written; broadcast tag 9 to READY register this cycle
        cyc(0, 0, 0, 4'd3, 4'd0, 1, 4'd9, D2);
        expect_rd(0, 0, 0, D1, "R4");
        // R5: broadcast to READY register ignored; claim reg 7 tag 2
        cyc(1, 4'd7, 4'd2, 4'd3, 4'd0, 0, 0, '0);
        expect_rd(0, 0, 0, D1, "R5");
        // R6: reclaim reg 7 (tag 4) in the completion cycle of tag 2
        cyc(1, 4'd7, 4'd4, 4'd7, 4'd3, 1, 4'd2, D3);
        expect_rd(0, 0, 0, D3, "R7"); expect_rd(1, 0, 0, D1, "R2");
        cyc(0, 0, 0, 4'd7, 4'd0, 0, 0, '0);
        expect_rd(0, 1, 4'd4, '0, "R6");
        // claim reg 15 tag 15; retire reg 7 via tag 4
        cyc(1, 4'd15, 4'd15, 4'd15, 4'd7, 1, 4'd4, D4);
        expect_rd(0, 0, 0, '0, "R8"); expect_rd(1, 0, 0, D4, "R7");
        cyc(0, 0, 0, 4'd7, 4'd15, 1, 4'd15, D2);
        expect_rd(0, 0, 0, D4, "R4"); expect_rd(1, 0, 0, D2, "R7");
        cyc(0, 0, 0, 4'd15, 4'd7, 0, 0, '0);
        expect_rd(0, 0, 0, D2, "R4"); expect_rd(1, 0, 0, D4, "R2");
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule